// File: doc/BRIEF.md
# Dual-Motor Inverted PWM Driver

This block drives two brushed DC motors, each through an H-bridge with two control lines. A prescaler divides the system clock by eight to make a timer tick. Each motor has its own free-running 8-bit counter that advances on that tick. Each of the four control lines compares its counter against an 8-bit compare value and makes an inverted fast-PWM waveform. The line is low from the counter wrap until the compare point and high for the rest of the period.

Software or a controller issues one command per motor. A command carries a motor select, a direction bit and an 8-bit speed. The block turns the command into two compare values. The idle line gets the minimum-low setting, so it is parked high. The other line gets the speed as its compare value, so a larger speed means a longer low time. Commands land in a shadow register and move into the active compare register only when that motor's counter wraps. Because of this, a period is never cut short, and both lines of a motor change in the same clock.

Top module: `dual_motor_pwm`

## Requirements
- R1: While reset is asserted and in the first clock after it, all control lines are high and all compare values hold 0.
- R2: Each counter advances once every 8 system clocks, so one PWM period lasts 2048 clocks. A line falls at the same point in every period.
- R3: A line with active compare value C is low for (C+1)×8 clocks per period. The low time starts in the clock after the counter reaches 0. The line goes high in the clock after the counter first exceeds C.
- R4: A speed of 255 holds the modulated line constantly low. This is full speed.
- R5: A speed of 0 sets both lines of that motor to compare 0. Each line is then low for only 8 clocks per period.
- R6: With direction 0, line 2m (the even line) of motor m is modulated and line 2m+1 (the odd line) is idle with compare 0. With direction 1 the roles of the two lines swap.
- R7: A command takes effect only at the next wrap of that motor's counter. Until then the lines keep the waveform of the old command.
- R8: When a command's new values take effect, both lines of the motor switch to them in the same clock.
- R9: A command for one motor leaves the other motor's lines unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe; the command is taken in the clock where this is high |
| cmd_motor | input | 1 | Motor select: 0 or 1 |
| cmd_dir | input | 1 | Direction: 0 modulates the even line, 1 modulates the odd line |
| cmd_speed | input | 8 | Speed; it becomes the compare value of the modulated line |
| ctl_line | output | 4 | Control lines; bits 0 and 1 drive motor 0, bits 2 and 3 drive motor 1 |

## Verification
Each control line is a register fed by its counter and its active compare value. A line therefore shows a counter or compare change one clock later.

A command first waits for the next wrap of its motor's counter. That wrap can come up to 2048 clocks after the strobe. From the wrap, the new level shows on the lines one clock later.

The bench model uses the same lag. It samples its input at each rising edge and compares the outputs at the falling edge. Duty-cycle checks wait two full periods after a command, then count low clocks over a window of exactly 2048 clocks.

The deferral check samples mid-period. At that point the old command and the new command would give different levels.

// File: rtl/dual_motor_pwm.sv
`timescale 1ns/1ps
module dual_motor_pwm #(
  parameter int CW       = 8,
  parameter int PRESCALE = 8,
  parameter int MOTORS   = 2,
  parameter int SEL_W    = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [SEL_W-1:0]      cmd_motor,
  input  logic                  cmd_dir,
  input  logic [CW-1:0]         cmd_speed,
  output logic [2*MOTORS-1:0]   ctl_line
);
  localparam int PW = $clog2(PRESCALE);
  localparam logic [CW-1:0] TOP = '1;

  logic [PW-1:0] pre_q;
  logic          tick;
  logic [MOTORS-1:0][CW-1:0]   cnt_all;
  logic [2*MOTORS-1:0][CW-1:0] act_all;
  logic [MOTORS-1:0]           wrap;

  assign tick = (pre_q == PW'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || tick) pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

  for (genvar m = 0; m < MOTORS; m++) begin : g_motor
    logic [CW-1:0]       cnt;
    logic [1:0][CW-1:0]  shd, act;
    logic [1:0]          lv;
    logic                hit;

    assign hit        = cmd_valid && (cmd_motor == SEL_W'(m));
    assign wrap[m]    = tick && (cnt == TOP);
    assign cnt_all[m] = cnt;
    assign act_all[2*m]   = act[0];
    assign act_all[2*m+1] = act[1];
    assign ctl_line[2*m +: 2] = lv;

    always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shd <= '0;
      end else if (hit) begin
        shd[0] <= cmd_dir ? '0 : cmd_speed;
        shd[1] <= cmd_dir ? cmd_speed : '0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)       act <= '0;
      else if (wrap[m]) act <= shd;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) lv <= 2'b11;
      else        lv <= {cnt > act[1], cnt > act[0]};
    end
  end
endmodule

module dual_motor_pwm_chk #(
  parameter int CW     = 8,
  parameter int MOTORS = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        tick,
  input logic [MOTORS-1:0][CW-1:0]   cnt_all,
  input logic [2*MOTORS-1:0][CW-1:0] act_all,
  input logic [MOTORS-1:0]           wrap,
  input logic [2*MOTORS-1:0]         ctl_line
);
  // R1
  reset_lines_high_chk: assert property (@(posedge clk)
    !rst_n |=> (ctl_line == '1));

  for (genvar m = 0; m < MOTORS; m++) begin : g_mchk
    // R2
    cnt_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cnt_all[m]) |-> $past(tick));
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt_all[m] == CW'($past(cnt_all[m]) + 1'b1)));
    // R7
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap[m] |=> ($stable(act_all[2*m]) && $stable(act_all[2*m+1])));
  end

  for (genvar i = 0; i < 2*MOTORS; i++) begin : g_lchk
    // R3
    line_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl_line[i]) |-> ($past(cnt_all[i/2]) == '0));
    // R3
    line_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_line[i]) |-> ($past(cnt_all[i/2]) == CW'($past(act_all[i]) + 1'b1)));
    // R4
    full_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(act_all[i]) == '1) |-> !ctl_line[i]);
  end
endmodule

bind dual_motor_pwm dual_motor_pwm_chk #(.CW(CW), .MOTORS(MOTORS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_all(cnt_all),
  .act_all(act_all), .wrap(wrap), .ctl_line(ctl_line)
);

// File: tb/dual_motor_pwm_test.sv
`timescale 1ns/1ps
module dual_motor_pwm_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_motor = 1'b0;
  logic       cmd_dir = 1'b0;
  logic [7:0] cmd_speed = 8'd0;
  logic [3:0] ctl_line;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  int  m_pre, m_cnt;
  int  m_act[4];
  int  m_shd[4];
  logic [3:0] exp_line = 4'hF;
  bit  model_on = 1'b0;

  always #4 clk = ~clk;

  dual_motor_pwm uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_motor(cmd_motor),
    .cmd_dir(cmd_dir), .cmd_speed(cmd_speed), .ctl_line(ctl_line)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: a line is low while the counter sits at or below its compare value
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; exp_line = 4'hF;
      for (int i = 0; i < 4; i++) begin m_act[i] = 0; m_shd[i] = 0; end
    end else begin
      for (int i = 0; i < 4; i++) exp_line[i] = (m_cnt > m_act[i]);
      if (m_pre == 7 && m_cnt == 255)
        for (int i = 0; i < 4; i++) m_act[i] = m_shd[i];
      if (cmd_valid) begin
        m_shd[2*cmd_motor]   = cmd_dir ? 0 : int'(cmd_speed);
        m_shd[2*cmd_motor+1] = cmd_dir ? int'(cmd_speed) : 0;
      end
      if (m_pre == 7) begin m_pre = 0; m_cnt = (m_cnt + 1) % 256; end
      else m_pre = m_pre + 1;
    end
  end

  always @(negedge clk) begin
    if (model_on) check(ctl_line == exp_line, cur_req, ctl_line, exp_line);
  end

  task automatic send(input logic mot, input logic dir, input logic [7:0] spd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_motor = mot; cmd_dir = dir; cmd_speed = spd;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_fall(input int idx);
    logic p;
    p = ctl_line[idx];
    forever begin
      @(negedge clk);
      if (p && !ctl_line[idx]) break;
      p = ctl_line[idx];
    end
  endtask

  task automatic measure_low(input int idx, input int exp, input string req);
    int n;
    n = 0;
    repeat (2048) begin
      @(negedge clk);
      if (!ctl_line[idx]) n++;
    end
    check(n == exp, req, n, exp);
  endtask

  initial begin
    int n;
    wait_clks(5);
    check(ctl_line == 4'hF, "R1", ctl_line, 15);
    model_on = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ctl_line == 4'h0, "R1", ctl_line, 0);

    cur_req = "R2";
    wait_fall(0);
    n = 0;
    begin
      logic p;
      p = ctl_line[0];
      forever begin
        @(negedge clk); n++;
        if (p && !ctl_line[0]) break;
        p = ctl_line[0];
      end
    end
    check(n == 2048, "R2", n, 2048);

    cur_req = "R5";
    measure_low(0, 8, "R5");
    measure_low(3, 8, "R5");

    cur_req = "R3";
    send(0, 0, 8'd127);
    wait_clks(4096);
    measure_low(0, 1024, "R3");
    measure_low(1, 8, "R6");

    cur_req = "R4";
    send(0, 0, 8'd255);
    wait_clks(4096);
    measure_low(0, 2048, "R4");

    cur_req = "R6";
    send(0, 1, 8'd64);
    wait_clks(4096);
    measure_low(0, 8, "R6");
    measure_low(1, 520, "R6");

    cur_req = "R9";
    send(1, 1, 8'd200);
    wait_clks(4096);
    measure_low(2, 8, "R9");
    measure_low(3, 1608, "R9");
    measure_low(1, 520, "R9");

    cur_req = "R7";
    wait_fall(1);
    send(0, 0, 8'd200);
    wait_clks(1000);
    check(ctl_line[0] == 1'b1, "R7", ctl_line[0], 1);
    check(ctl_line[1] == 1'b1, "R7", ctl_line[1], 1);
    cur_req = "R8";
    wait_clks(2048);
    check(ctl_line[0] == 1'b0, "R8", ctl_line[0], 0);
    check(ctl_line[1] == 1'b1, "R8", ctl_line[1], 1);

    cur_req = "R5";
    send(0, 0, 8'd0);
    wait_clks(4096);
    measure_low(0, 8, "R5");
    measure_low(1, 8, "R5");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule